// File: doc/BRIEF.md
# MDIO PHY Presence Poller

This block is a management-bus master that, once enabled, runs on its own to find which PHY devices are attached to a shared MDIO line. It makes the management clock MDC from the core clock through a programmable divider. It then issues read frames to PHY addresses 0, 1, 2 and onward, up to 31, and starts again at 0 without stopping. Each frame reads one fixed status register, set by a parameter.

A PHY that answers pulls the line low in the second turnaround bit. The result of each frame is written into one bit of a 32-bit presence map. A frame that saw a response sets its bit, and a frame that saw none clears it. When a frame changes the map, the block can send a one-cycle interrupt pulse. A mask input decides whether it does. A further control input can leave out the 32-bit preamble, so that accesses are shorter when every attached PHY accepts frames without one.

Top module: `mdio_poller`

## Requirements
- R1: While en_i is 0, mdc_o and mdio_oe_o stay 0 and no frame is started. After en_i rises, the first frame addresses PHY 0.
- R2: Each MDC half-period lasts max(div_i,1) core clock cycles, so the MDC period is 2*max(div_i,1) cycles. A divider value of 0 gives a period of 2 cycles.
- R3: With no_pre_i=0, the block drives the following bits in this order: 32 ones, then 0,1 (start), then 1,0 (read), then the 5-bit PHY address MSB first, then the 5-bit register address STAT_REG (default 1) MSB first. That is 46 bits with mdio_oe_o=1. mdio_oe_o is then 0 for the 2 turnaround bits and the 16 data bits.
- R4: With no_pre_i=1, a frame leaves out the preamble. It drives only the 14 start, opcode and address bits before it releases the line.
- R5: mdio_o changes only together with a falling edge of mdc_o. mdio_i is sampled at the rising MDC edge of the second turnaround bit.
- R6: At the end of each frame, bit n of alive_o takes the value 1 if mdio_i was 0 at that sample in the frame to PHY n, and 0 otherwise.
- R7: The PHY address rises by one from each frame to the next. It wraps from 31 to 0, and frames follow each other without pause.
- R8: irq_o pulses high for one cycle after each frame that changed alive_o, but only if irq_en_i is 1. A frame that leaves the map unchanged gives no pulse.
- R9: Reset clears alive_o to 0. Dropping en_i keeps alive_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run the poller |
| div_i | input | DIV_W | MDC half-period in core cycles (0 acts as 1) |
| no_pre_i | input | 1 | Leave out the preamble |
| irq_en_i | input | 1 | Unmask the map-change interrupt |
| mdio_i | input | 1 | MDIO line as read back |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe_o | output | 1 | MDIO drive enable |
| alive_o | output | 32 | Presence map, bit n for PHY n |
| irq_o | output | 1 | Map-change interrupt pulse |

## Verification
Two things happen on the same falling MDC edge when the frame to PHY 31 ends. The presence bit 31 is written, with its interrupt, and the address counter wraps to 0 while the next frame starts. The bench provokes this by placing a modelled PHY at address 31. It then checks that bit 31 is set, that the interrupt count matches the number of changed bits, and that the next captured header carries address 0 with no break in the address sequence. The bench's PHY model decodes each header from the line itself and answers only for the addresses it has been told are present.

// File: rtl/mdio_poller_pkg.sv
package mdio_poller_pkg;
  localparam int unsigned PHY_AW   = 5;
  localparam int unsigned REG_AW   = 5;
  localparam int unsigned N_PHY    = 1 << PHY_AW;
  localparam int unsigned PRE_LEN  = 32;
  localparam int unsigned HDR_LEN  = 4 + PHY_AW + REG_AW;
  localparam int unsigned TA_LEN   = 2;
  localparam int unsigned DATA_LEN = 16;
  localparam int unsigned FRM_LEN  = PRE_LEN + HDR_LEN + TA_LEN + DATA_LEN;
  localparam int unsigned IDX_W    = $clog2(FRM_LEN);

  localparam logic [1:0] ST_CODE = 2'b01;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef logic [PHY_AW-1:0] phy_addr_t;
  typedef logic [REG_AW-1:0] reg_addr_t;
  typedef logic [IDX_W-1:0]  bit_idx_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, lim, lim_m1;
  logic             mdc_q, tick;

  assign lim    = (div_i == '0) ? ONE : div_i;
  assign lim_m1 = lim - ONE;
  assign tick   = en_i && (cnt_q >= lim_m1);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  AST_MDC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mdc_o); // R1
  AST_MDC_RISE_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_q) |-> $past(en_i)); // R2
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_poller_pkg::*;
#(
  parameter reg_addr_t STAT_REG = 5'd1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      rise_i,
  input  logic      fall_i,
  input  logic      no_pre_i,
  input  logic      mdio_i,
  input  phy_addr_t addr_i,
  output logic      mdio_o,
  output logic      mdio_oe_o,
  output logic      done_o,
  output logic      resp_o
);
  localparam bit_idx_t IDX_HDR  = bit_idx_t'(PRE_LEN);
  localparam bit_idx_t IDX_REL  = bit_idx_t'(PRE_LEN + HDR_LEN);
  localparam bit_idx_t IDX_TA2  = bit_idx_t'(PRE_LEN + HDR_LEN + 1);
  localparam bit_idx_t IDX_LAST = bit_idx_t'(FRM_LEN - 1);
  localparam bit_idx_t IDX_HTOP = bit_idx_t'(PRE_LEN + HDR_LEN - 1);
  localparam bit_idx_t ONE      = bit_idx_t'(1);

  logic                busy_q, resp_q, start, drv_bit;
  bit_idx_t            idx_q, hpos;
  logic [HDR_LEN-1:0]  hdr;

  assign start = fall_i && (!busy_q || idx_q == IDX_LAST);
  assign hdr   = {ST_CODE, OP_READ, addr_i, STAT_REG};
  assign hpos  = IDX_HTOP - idx_q;

  always_comb begin
    if (idx_q < IDX_HDR) drv_bit = 1'b1;
    else                 drv_bit = hdr[hpos[3:0]];
  end

  assign mdio_oe_o = busy_q && (idx_q < IDX_REL);
  assign mdio_o    = mdio_oe_o && drv_bit;
  assign done_o    = fall_i && busy_q && (idx_q == IDX_LAST);
  assign resp_o    = resp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      resp_q <= 1'b0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      resp_q <= 1'b0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= no_pre_i ? IDX_HDR : '0;
        resp_q <= 1'b0;
      end else if (fall_i && busy_q) begin
        idx_q <= idx_q + ONE;
      end
      if (rise_i && busy_q && idx_q == IDX_TA2) resp_q <= !mdio_i;
    end
  end

  AST_DRIVE_AT_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$past(fall_i)) |-> $stable(mdio_o)); // R5
  AST_TA_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && busy_q && idx_q == IDX_TA2) |-> !mdio_oe_o); // R3
endmodule

// File: rtl/mdio_scan.sv
module mdio_scan
  import mdio_poller_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             done_i,
  input  logic             resp_i,
  input  logic             irq_en_i,
  output phy_addr_t        addr_o,
  output logic [N_PHY-1:0] alive_o,
  output logic             irq_o
);
  phy_addr_t        addr_q;
  logic [N_PHY-1:0] alive_q;
  logic             irq_q, changed;

  assign changed = done_i && (alive_q[addr_q] != resp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= changed && irq_en_i;
      if (!en_i)       addr_q <= '0;
      else if (done_i) addr_q <= addr_q + phy_addr_t'(1);
    end
  end

  for (genvar g = 0; g < N_PHY; g++) begin : g_map
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       alive_q[g] <= 1'b0;
      else if (done_i && addr_q == phy_addr_t'(g))       alive_q[g] <= resp_i;
    end
  end

  assign addr_o  = addr_q;
  assign alive_o = alive_q;
  assign irq_o   = irq_q;

  AST_ADDR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && done_i && addr_q == phy_addr_t'(N_PHY - 1)) |=> addr_q == '0); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !done_i) |=> $stable(addr_q)); // R7
  AST_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> $countones(alive_q ^ $past(alive_q)) <= 1); // R6
  AST_MAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(alive_q)); // R9
  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(irq_en_i)); // R8
endmodule

// File: rtl/mdio_poller.sv
module mdio_poller
  import mdio_poller_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter reg_addr_t   STAT_REG = 5'd1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             no_pre_i,
  input  logic             irq_en_i,
  input  logic             mdio_i,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  output logic [31:0]      alive_o,
  output logic             irq_o
);
  logic      rise, fall, done, resp;
  phy_addr_t addr;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk_i, .rst_ni, .en_i, .div_i,
    .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_frame #(.STAT_REG(STAT_REG)) u_frame (
    .clk_i, .rst_ni, .en_i,
    .rise_i(rise), .fall_i(fall), .no_pre_i, .mdio_i, .addr_i(addr),
    .mdio_o, .mdio_oe_o, .done_o(done), .resp_o(resp)
  );

  mdio_scan u_scan (
    .clk_i, .rst_ni, .en_i,
    .done_i(done), .resp_i(resp), .irq_en_i,
    .addr_o(addr), .alive_o, .irq_o
  );
endmodule

// File: tb/mdio_poller_tb_top.sv
`timescale 1ns/1ps
module mdio_poller_tb_top;
  localparam int DIV_W = 8;
  localparam logic [4:0] STAT_REG = 5'd1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i = 1'b0, no_pre_i = 1'b0, irq_en_i = 1'b0;
  logic [DIV_W-1:0] div_i = 8'd1;
  logic mdio_i, mdc_o, mdio_o, mdio_oe_o, irq_o;
  logic [31:0] alive_o;
  logic [31:0] present = '0;

  always #5 clk_i = ~clk_i;

  mdio_poller #(.DIV_W(DIV_W), .STAT_REG(STAT_REG)) dut_i (.*);

  // Bench-side PHY model and line monitor
  logic [63:0] sh = '0, last_sh = '0;
  int oe_bits = 0, last_len = 0, frames_seen = 0, seq_err = 0;
  int irq_cnt = 0, mdc_rises = 0, oe_hi = 0, r5_viol = 0;
  logic hdr_valid = 1'b0, have_prev = 1'b0;
  logic [4:0] hdr_addr = '0, prev_addr = '0;
  logic prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;

  assign mdio_i = (hdr_valid && !mdio_oe_o && present[hdr_addr]) ? 1'b0 : 1'b1;

  always @(posedge clk_i) begin
    if (irq_o) irq_cnt++;
    if (mdio_oe_o) oe_hi++;
    if (mdio_oe_o && prev_oe && mdio_o != prev_o && !(prev_mdc && !mdc_o)) r5_viol++;
    if (!en_i) begin
      have_prev = 1'b0;
      hdr_valid = 1'b0;
      oe_bits = 0;
    end
    if (mdc_o && !prev_mdc) begin
      mdc_rises++;
      if (mdio_oe_o) begin
        sh = {sh[62:0], mdio_o};
        oe_bits++;
        hdr_valid = 1'b0;
      end else if (oe_bits != 0) begin
        last_len = oe_bits;
        last_sh = sh;
        oe_bits = 0;
        hdr_addr = sh[9:5];
        hdr_valid = 1'b1;
        if (have_prev && sh[9:5] != prev_addr + 5'd1) seq_err++;
        prev_addr = sh[9:5];
        have_prev = 1'b1;
        frames_seen++;
      end
    end
    prev_mdc = mdc_o;
    prev_o = mdio_o;
    prev_oe = mdio_oe_o;
  end

  int n_chk = 0, n_err = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_frames(input int n);
    int base;
    base = frames_seen;
    while (frames_seen < base + n) @(negedge clk_i);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1", {31'd0, mdc_o}, 0, "mdc after reset");
    chk("R1", {31'd0, mdio_oe_o}, 0, "oe after reset");
    chk("R9", alive_o, 0, "map after reset");
    chk("R8", {31'd0, irq_o}, 0, "irq after reset");
  endtask

  task automatic t_disabled;
    int r0, o0;
    r0 = mdc_rises; o0 = oe_hi;
    div_i = 8'd2;
    repeat (200) @(negedge clk_i);
    chk("R1", mdc_rises - r0, 0, "mdc edges while disabled");
    chk("R1", oe_hi - o0, 0, "drive while disabled");
  endtask

  task automatic t_div(input logic [7:0] d, input int exp_cyc);
    realtime t0, t1;
    div_i = d;
    en_i = 1'b1;
    @(posedge mdc_o); t0 = $realtime;
    @(posedge mdc_o); t1 = $realtime;
    chk("R2", int'((t1 - t0) / 10.0), exp_cyc, "mdc period");
    @(negedge clk_i);
    en_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_first_frame;
    present = 32'h8000_0025;
    div_i = 8'd1;
    no_pre_i = 1'b0;
    irq_en_i = 1'b1;
    @(negedge clk_i);
    en_i = 1'b1;
    wait_frames(1);
    chk("R3", last_len, 46, "driven bits with preamble");
    chk("R3", last_sh[45:14], 32'hFFFF_FFFF, "preamble ones");
    chk("R3", {28'd0, last_sh[13:10]}, 32'h6, "start and read code");
    chk("R3", {27'd0, last_sh[4:0]}, {27'd0, STAT_REG}, "register address");
    chk("R1", {27'd0, last_sh[9:5]}, 0, "first address after enable");
  endtask

  task automatic t_scan;
    int i0;
    i0 = irq_cnt - 0;
    wait_frames(32);
    repeat (4) @(negedge clk_i);
    chk("R6", alive_o, 32'h8000_0025, "map after first scan incl. wrap at 31");
    chk("R7", seq_err, 0, "address sequence");
    chk("R8", irq_cnt, 4, "irq pulses for four new PHYs");
  endtask

  task automatic t_remove;
    int i0;
    irq_en_i = 1'b0;
    present = 32'h8000_0004;
    i0 = irq_cnt;
    wait_frames(33);
    chk("R6", alive_o, 32'h8000_0004, "map after PHYs leave");
    chk("R8", irq_cnt - i0, 0, "masked irq");
  endtask

  task automatic t_stable;
    int i0;
    irq_en_i = 1'b1;
    i0 = irq_cnt;
    wait_frames(33);
    chk("R8", irq_cnt - i0, 0, "no irq on unchanged map");
  endtask

  task automatic t_nopre;
    int i0;
    no_pre_i = 1'b1;
    present = 32'h8000_0404;
    i0 = irq_cnt;
    wait_frames(2);
    chk("R4", last_len, 14, "driven bits without preamble");
    chk("R4", {28'd0, last_sh[13:10]}, 32'h6, "start code without preamble");
    wait_frames(33);
    chk("R6", alive_o, 32'h8000_0404, "map without preamble");
    chk("R8", irq_cnt - i0, 1, "one irq for one new PHY");
    chk("R7", seq_err, 0, "sequence without preamble");
  endtask

  task automatic t_retain;
    int r0;
    @(negedge clk_i);
    en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    r0 = mdc_rises;
    present = '0;
    repeat (300) @(negedge clk_i);
    chk("R9", alive_o, 32'h8000_0404, "map kept while disabled");
    chk("R1", mdc_rises - r0, 0, "mdc idle while disabled");
    en_i = 1'b1;
    wait_frames(1);
    chk("R1", {27'd0, hdr_addr}, 0, "restart at address 0");
    chk("R5", r5_viol, 0, "mdio changes only at falling mdc");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_err++; n_chk++;
    $display("FAIL R7 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_disabled();
    t_div(8'd3, 6);
    t_div(8'd0, 2);
    t_div(8'd1, 2);
    t_first_frame();
    t_scan();
    t_remove();
    t_stable();
    t_nopre();
    t_retain();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule